// File: doc/BRIEF.md
# Variable-Length Serial Peripheral Master

This block is a master for a four-wire serial peripheral link with eight chip-select lines. A host writes a configuration word (prescaler, clock idle level, word length and chip-select mask), writes a transmit word, and then pulses a start input. The block shifts 8, 16, 24 or 32 bits out on the serial data output while it captures the same number of bits from the serial data input. It then raises a one-cycle completion pulse and leaves the received bits, zero-extended, on its receive output.

Everything runs on the system clock. The serial clock is a flop output that toggles each time a half-period counter expires. The selected chip-select lines stay low for the whole word. Transfers use one phase convention: the input is sampled on the leading serial-clock edge and the output changes on the trailing edge. A polarity bit chooses the idle level of the serial clock.

Top module: `spim_top`

## Requirements
- R1: After synchronous reset, busy and done are 0, every chip-select line is 1, sclk is 0, mosi is 0 and rx_data is 0.
- R2: cfg_wdata bits [9:8] select the word length: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. With prescaler value N, busy stays high for exactly 2·bits·(N+1) clock cycles after the start edge.
- R3: mosi carries the transmit word most significant bit first, beginning at bit (bits−1). Bits above the selected length are not sent. mosi changes only on trailing serial-clock edges.
- R4: miso is sampled on each leading serial-clock edge and shifted in at the least significant end. At completion, rx_data holds the received bits with zeros above the selected length.
- R5: cfg_wdata bit 10 sets the idle level of sclk. sclk shows the new idle level on the cycle after a configuration write accepted while idle, and it returns to that level at the end of every transfer.
- R6: cfg_wdata bits [7:0] form the chip-select mask. While busy, cs_n[i] is 0 exactly when mask bit i is 1. Whenever the block is idle, all of cs_n is 1.
- R7: done is high for exactly one cycle, on the same cycle that busy falls.
- R8: While busy, writes to the configuration and transmit registers are ignored, and so is a start pulse. The running transfer keeps its length, timing and chip selects. A later transfer started without a new transmit write sends the earlier word.
- R9: cfg_wdata bits [18:11] hold the prescaler N. The first sclk edge comes N+1 cycles after the start edge, and every half period of sclk is N+1 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 19 | Configuration word: mask [7:0], length [9:8], idle level [10], prescaler [18:11] |
| tx_we | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit word |
| start | input | 1 | Begin a transfer (accepted only while idle) |
| rx_data | output | 32 | Received bits, zero-extended |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions take three things for granted. The prescaler and length registers hold still for the duration of a transfer. Reset is applied before the first transfer. A start pulse never arrives on the same cycle as the configuration write it depends on. The bench writes configuration and data only while the block is idle and waits at least one cycle before starting, except in the deliberate in-flight pokes that exercise the ignore rule. Its slave model changes miso only after trailing serial-clock edges, so the value the master samples has been stable for at least one cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    LEN_8  = 2'd0,
    LEN_16 = 2'd1,
    LEN_24 = 2'd2,
    LEN_32 = 2'd3
  } len_e;

  // number of bits shifted for a length code (byte granularity)
  function automatic int unsigned len_bits(input len_e code);
    return (int'(code) + 1) * 8;
  endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tick
);

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == presc) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == presc);

  // half-period counter never runs past the prescaler during a transfer (R9)
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> (cnt_q <= presc));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              lead,
  input  logic              trail,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] tx_sr_q;
  logic [WORD_W-1:0] rx_sr_q;
  logic              mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      mosi_q  <= 1'b0;
    end else if (load) begin
      tx_sr_q <= load_word;
      rx_sr_q <= '0;
      mosi_q  <= load_word[WORD_W-1];
    end else begin
      if (lead) begin
        rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso};
      end
      if (trail) begin
        tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
        mosi_q  <= tx_sr_q[WORD_W-2];
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_sr_q;

  // output bit never moves on a leading edge (R3)
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (lead && !load) |=> $stable(mosi_q));

  // nothing enters the receive register except on a leading edge or load (R4)
  p_rx_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!lead && !load) |=> $stable(rx_sr_q));

endmodule

// File: rtl/spim_top.sv
module spim_top #(
  parameter int WORD_W  = 32,
  parameter int PRESC_W = 8,
  parameter int NCS     = 8,
  localparam int CFG_W  = NCS + 3 + PRESC_W,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              tx_we,
  input  logic [WORD_W-1:0] tx_wdata,
  input  logic              start,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  import spim_pkg::*;

  localparam int LEN_LSB   = NCS;
  localparam int POL_BIT   = NCS + 2;
  localparam int PRESC_LSB = NCS + 3;

  // configuration and data holding registers
  logic [NCS-1:0]     mask_q;
  len_e               len_q;
  logic               cpol_q;
  logic [PRESC_W-1:0] presc_q;
  logic [WORD_W-1:0]  tx_q;

  // transfer state
  logic               busy_q;
  logic               phase_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic               sclk_q;
  logic [NCS-1:0]     cs_n_q;
  logic               done_q;

  logic               tick;
  logic               lead;
  logic               trail;
  logic               accept;
  logic               last;
  logic [CNT_W-1:0]   nbits;
  logic [WORD_W-1:0]  aligned;

  assign nbits   = CNT_W'(len_bits(len_q));
  assign aligned = tx_q << (WORD_W - int'(nbits));
  assign lead    = tick && !phase_q;
  assign trail   = tick && phase_q;
  assign accept  = start && !busy_q;
  assign last    = trail && (bit_cnt_q == nbits);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      len_q   <= LEN_8;
      cpol_q  <= 1'b0;
      presc_q <= '0;
      tx_q    <= '0;
    end else if (!busy_q) begin
      if (cfg_we) begin
        mask_q  <= cfg_wdata[NCS-1:0];
        len_q   <= len_e'(cfg_wdata[LEN_LSB +: 2]);
        cpol_q  <= cfg_wdata[POL_BIT];
        presc_q <= cfg_wdata[PRESC_LSB +: PRESC_W];
      end
      if (tx_we) begin
        tx_q <= tx_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      phase_q   <= 1'b0;
      bit_cnt_q <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= '1;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cfg_we) begin
          sclk_q <= cfg_wdata[POL_BIT];
        end
        if (accept) begin
          busy_q    <= 1'b1;
          phase_q   <= 1'b0;
          bit_cnt_q <= '0;
          cs_n_q    <= ~mask_q;
        end
      end else if (lead) begin
        phase_q   <= 1'b1;
        sclk_q    <= ~cpol_q;
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end else if (trail) begin
        phase_q <= 1'b0;
        sclk_q  <= cpol_q;
        if (last) begin
          busy_q <= 1'b0;
          cs_n_q <= '1;
          done_q <= 1'b1;
        end
      end
    end
  end

  spim_clkgen #(
    .PRESC_W(PRESC_W)
  ) clkgen_i (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .presc(presc_q),
    .tick (tick)
  );

  spim_shifter #(
    .WORD_W(WORD_W)
  ) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_word(aligned),
    .lead     (lead),
    .trail    (trail),
    .miso     (miso),
    .mosi     (mosi),
    .rx_word  (rx_data)
  );

  assign busy = busy_q;
  assign done = done_q;
  assign sclk = sclk_q;
  assign cs_n = cs_n_q;

  // all selects released whenever idle (R6)
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cs_n_q == '1));

  // select pattern does not move inside a word (R6)
  p_cs_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(cs_n_q));

  // serial clock rests at the programmed idle level (R5)
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (sclk_q == cpol_q));

  // completion pulse coincides with the fall of busy (R7)
  p_done_end_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));

  // length does not change mid-transfer (R8)
  p_len_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(len_q));

  // leading-edge count never exceeds the word length (R2)
  p_bits_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (bit_cnt_q <= nbits));

  // an idle start is always taken (R8)
  p_start_take_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);

endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic        tx_we = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] rx_data;
  logic        busy;
  logic        done;
  logic        sclk;
  logic        mosi;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spim_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .start(start), .rx_data(rx_data),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [18:0] mk_cfg(input int presc, input bit pol,
                                         input int len, input logic [7:0] mask);
    return {8'(presc), pol, 2'(len), mask};
  endfunction

  function automatic logic [31:0] low_mask(input int nb);
    return (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
  endfunction

  task automatic write_cfg(input logic [18:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_tx(input logic [31:0] w);
    @(negedge clk); tx_we = 1'b1; tx_wdata = w;
    @(negedge clk); tx_we = 1'b0;
  endtask

  // runs one transfer with a bench slave; poke injects in-flight writes
  task automatic run_xfer(input int presc, input bit pol, input int len,
                          input logic [7:0] mask, input logic [31:0] txw,
                          input logic [31:0] stx, input bit poke);
    int nb = (len + 1) * 8;
    int idx = nb - 1;
    int busy_cnt = 0;
    int first_edge = -1;
    int done_cnt = 0;
    int k = 0;
    int half_bad = 0;
    int run_len = 0;
    bit prev_sclk = pol;
    bit mosi_bad = 0;
    logic [31:0] srx = '0;
    logic [31:0] m = low_mask(nb);
    bit prev_mosi;
    miso = stx[idx];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    prev_mosi = mosi;
    forever begin
      tx_we = 1'b0; cfg_we = 1'b0; start = 1'b0;
      if (poke && k == 3) begin
        tx_we = 1'b1; tx_wdata = ~txw;
        cfg_we = 1'b1; cfg_wdata = mk_cfg(7, ~pol, 0, 8'h5A);
        start = 1'b1;
      end
      if (busy) busy_cnt++;
      if (done) done_cnt++;
      if (k == 2) check(cs_n == ~mask, "R6", "cs_n while busy", {24'd0, cs_n}, {24'd0, ~mask});
      if (sclk != prev_sclk) begin
        if (first_edge < 0) first_edge = k;
        else if (run_len != presc + 1) half_bad = 1;
        run_len = 0;
        if (sclk != pol) begin
          srx = {srx[30:0], mosi};
          if (mosi != prev_mosi) mosi_bad = 1;
        end else begin
          idx--;
          if (idx >= 0) miso = stx[idx];
        end
      end
      run_len++;
      prev_sclk = sclk;
      prev_mosi = mosi;
      if (!busy || k > 5000) break;
      k++;
      @(negedge clk);
    end
    tx_we = 1'b0; cfg_we = 1'b0; start = 1'b0;
    check(busy_cnt == 2 * nb * (presc + 1), "R2", "busy duration",
          32'(busy_cnt), 32'(2 * nb * (presc + 1)));
    check(first_edge == presc + 1, "R9", "first sclk edge", 32'(first_edge), 32'(presc + 1));
    check(!half_bad, "R9", "half period length", 32'(half_bad), 32'd0);
    check((srx & m) == (txw & m), "R3", "bits seen on mosi", srx & m, txw & m);
    check(!mosi_bad, "R3", "mosi moved on leading edge", 32'(mosi_bad), 32'd0);
    check(rx_data == (stx & m), "R4", "rx_data", rx_data, stx & m);
    check(done_cnt == 1, "R7", "done with busy fall", 32'(done_cnt), 32'd1);
    check(sclk == pol, "R5", "sclk idle after transfer", 32'(sclk), 32'(pol));
    check(cs_n == 8'hFF, "R6", "cs_n after transfer", {24'd0, cs_n}, 32'hFF);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "busy/done after reset", {30'd0, busy, done}, 32'd0);
    check(cs_n == 8'hFF, "R1", "cs_n after reset", {24'd0, cs_n}, 32'hFF);
    check(sclk == 0 && mosi == 0, "R1", "sclk/mosi after reset", {30'd0, sclk, mosi}, 32'd0);
    check(rx_data == 32'd0, "R1", "rx_data after reset", rx_data, 32'd0);

    for (int p = 0; p < 3; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int len = 0; len < 4; len++) begin
          int presc = (p == 2) ? 3 : p;
          logic [7:0] mask = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'((n * 37) ^ (1 << (n % 8)));
          logic [31:0] txw = 32'hA5C3_96E1 ^ (32'(n) * 32'h01F3_3B17);
          logic [31:0] stx = {txw[15:0], ~txw[31:16]} ^ (32'(n) * 32'h0101_0101);
          write_cfg(mk_cfg(presc, pol[0], len, mask));
          @(negedge clk);
          check(sclk == pol[0], "R5", "sclk after idle cfg write", 32'(sclk), 32'(pol));
          write_tx(txw);
          run_xfer(presc, pol[0], len, mask, txw, stx, 1'b0);
          n++;
        end
      end
    end

    // R8: in-flight writes and start are ignored
    write_cfg(mk_cfg(1, 1'b0, 1, 8'h81));
    write_tx(32'h0000_C3A5);
    run_xfer(1, 1'b0, 1, 8'h81, 32'h0000_C3A5, 32'h0000_5E7D, 1'b1);
    // R8: second run without a new tx write resends the original word
    run_xfer(1, 1'b0, 1, 8'h81, 32'h0000_C3A5, 32'h0000_1234, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule